// File: doc/BRIEF.md
# Four-Common Multiplexed LCD Drive Sequencer

This block generates the electrode drive sequence for a glass LCD panel with four common electrodes, multiplexed at 1/4 duty with 1/2 bias. It runs from a 75 kHz clock. Each frame lasts 1000 clock cycles and is split into four equal common slots. Every common and segment output is a 2-bit level code: low, mid or high. An external analog stage turns each code into a voltage. The block alternates the polarity of the drive from one frame to the next, so that no cell sees a net DC voltage.

The segment pattern sits in a small register file that holds one nibble per segment. Bit c of a nibble gives the state of that segment while common c is selected. A write port replaces one nibble per cycle. Written data is staged first and only reaches the panel at the next slot boundary, so no slot ever shows a half-updated pattern.

A backup input and an enable input take the panel out of drive. While the panel is out of drive, every output sits at the low level. Segments are arranged in groups of four, and each group can be released for use as general-purpose pins. A released segment drives the low code and deasserts its output enable.

Top module: `lcd_mux_driver`

## Requirements
- R1: When driving, exactly one common is selected at a time. Each common stays selected for FRAME_CYC/NUM_COM cycles (250 by default), in the order 0, 1, 2, 3.
- R2: Level codes are 2'b00 for low, 2'b01 for mid and 2'b10 for high. The selected common is high in even frames and low in odd frames. Every unselected common is mid.
- R3: A segment whose nibble bit for the selected common is 1 drives the level opposite to the selected common. A segment whose bit is 0 drives the same level as the selected common. A driven, unreleased segment is never mid.
- R4: The drive polarity inverts every frame, that is, after every four slots.
- R5: While backup is 1, from the next cycle on, every common and segment output is low. When backup is released, the sequence restarts at slot 0 with even polarity.
- R6: After reset, every output is low until enable is 1. The cycle after enable is sampled high shows slot 0 with even polarity.
- R7: A write stores wr_nib for segment wr_addr. The new value first appears in the first cycle of the next slot, or when drive starts. Writes with wr_addr >= NUM_SEG are ignored.
- R8: When bit g of grp_release is 1, segments 4g to 4g+3 drive the low code and have seg_oe = 0 in the same cycle. All other segments have seg_oe = 1.
- R9: Reset clears every nibble, so a freshly enabled panel shows every segment off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz drive clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Panel drive enable |
| backup | input | 1 | Backup state; forces every output low |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | AW | Segment index to write |
| wr_nib | input | NUM_COM | Segment nibble; bit c applies while common c is selected |
| grp_release | input | NUM_GRP | Releases segment group g to general-purpose use |
| com_lvl | output | 2*NUM_COM | Level code of each common; common c is at bits [2c+1:2c] |
| seg_lvl | output | 2*NUM_SEG | Level code of each segment; segment s is at bits [2s+1:2s] |
| seg_oe | output | NUM_SEG | 1 where the segment pin drives LCD levels |

## Verification
The assertions check the following on every cycle:
- while driving, exactly one common is away from mid;
- a driven, unreleased segment never sits at mid;
- backup pulls every output low one cycle later;
- released groups drop their enables;
- the slot counter stays in range;
- polarity flips only on frame wrap;
- the displayed pattern changes only on a load.

Only the bench scenarios can show the remaining behaviour, which needs a reference model of the whole sequence: the exact slot length, the segment levels derived from staged and displayed data, the deferred visibility of writes that land on a slot boundary, and the restart after enable drops and returns.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_LOW  = 2'b00;
    localparam lvl_t LVL_MID  = 2'b01;
    localparam lvl_t LVL_HIGH = 2'b10;

    // mirror a full-swing level; mid stays mid
    function automatic lvl_t lvl_flip(input lvl_t l);
        lvl_t r;
        case (l)
            LVL_HIGH: r = LVL_LOW;
            LVL_LOW:  r = LVL_HIGH;
            default:  r = LVL_MID;
        endcase
        return r;
    endfunction

    // level of the selected common for a frame polarity
    function automatic lvl_t lvl_select(input logic pol);
        return pol ? LVL_LOW : LVL_HIGH;
    endfunction

endpackage

// File: rtl/lcd_mux_timebase.sv
module lcd_mux_timebase #(
    parameter int SLOT_CYC = 250,
    parameter int NUM_COM  = 4,
    localparam int TW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
    localparam int SW = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    output logic          running,
    output logic [SW-1:0] slot,
    output logic          pol,
    output logic          slot_end
);

    localparam logic [TW-1:0] TICK_LAST = TW'(SLOT_CYC - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_COM - 1);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] tick;
        logic [SW-1:0] slot;
        logic          pol;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_req;
        if (!run_req || !st_q.run) begin
            st_d.tick = '0;
            st_d.slot = '0;
            st_d.pol  = 1'b0;
        end else if (st_q.tick == TICK_LAST) begin
            st_d.tick = '0;
            if (st_q.slot == SLOT_LAST) begin
                st_d.slot = '0;
                st_d.pol  = ~st_q.pol;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running  = st_q.run;
    assign slot     = st_q.slot;
    assign pol      = st_q.pol;
    assign slot_end = st_q.run && (st_q.tick == TICK_LAST);

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick <= TICK_LAST); // R1

    AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && slot_end && st_q.slot == SLOT_LAST) |=> (st_q.pol != $past(st_q.pol))); // R4

    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && st_q.run && !(slot_end && st_q.slot == SLOT_LAST)) |=> $stable(st_q.pol)); // R4

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> (st_q.tick == '0 && st_q.slot == '0 && !st_q.pol && !st_q.run)); // R5

endmodule

// File: rtl/lcd_mux_pattern.sv
module lcd_mux_pattern #(
    parameter int NUM_SEG = 20,
    parameter int NUM_COM = 4,
    localparam int AW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_addr,
    input  logic [NUM_COM-1:0]               wr_nib,
    input  logic                             load,
    output logic [NUM_SEG-1:0][NUM_COM-1:0]  shown
);

    localparam logic [AW:0] SEG_LIMIT = (AW + 1)'(NUM_SEG);

    typedef struct packed {
        logic [NUM_SEG-1:0][NUM_COM-1:0] staged;
        logic [NUM_SEG-1:0][NUM_COM-1:0] shown;
    } pat_state_t;

    pat_state_t st_d, st_q;
    logic       addr_ok;

    assign addr_ok = ({1'b0, wr_addr} < SEG_LIMIT);

    always_comb begin
        st_d = st_q;
        // the copy reads the old staged value, so a write in a load cycle waits a slot
        if (load) begin
            st_d.shown = st_q.staged;
        end
        if (wr_en && addr_ok) begin
            st_d.staged[wr_addr] = wr_nib;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shown = st_q.shown;

    AST_SHOWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.shown)); // R7

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr_ok)) |=> $stable(st_q.staged)); // R7

endmodule

// File: rtl/lcd_mux_encoder.sv
module lcd_mux_encoder
    import lcd_mux_pkg::*;
#(
    parameter int NUM_SEG  = 20,
    parameter int NUM_COM  = 4,
    parameter int GRP_SIZE = 4,
    localparam int NUM_GRP = (NUM_SEG + GRP_SIZE - 1) / GRP_SIZE,
    localparam int SW      = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic                             running,
    input  logic [SW-1:0]                    slot,
    input  logic                             pol,
    input  logic [NUM_SEG-1:0][NUM_COM-1:0]  shown,
    input  logic [NUM_GRP-1:0]               grp_release,
    output logic [2*NUM_COM-1:0]             com_lvl,
    output logic [2*NUM_SEG-1:0]             seg_lvl,
    output logic [NUM_SEG-1:0]               seg_oe
);

    lvl_t sel_lvl;
    lvl_t on_lvl;

    assign sel_lvl = lvl_select(pol);
    assign on_lvl  = lvl_flip(sel_lvl);

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        always_comb begin
            if (!running) begin
                com_lvl[2*c +: 2] = LVL_LOW;
            end else if (slot == SW'(c)) begin
                com_lvl[2*c +: 2] = sel_lvl;
            end else begin
                com_lvl[2*c +: 2] = LVL_MID;
            end
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam int G = s / GRP_SIZE;
        logic seg_on;
        assign seg_on = shown[s][slot];
        always_comb begin
            if (!running || grp_release[G]) begin
                seg_lvl[2*s +: 2] = LVL_LOW;
            end else if (seg_on) begin
                seg_lvl[2*s +: 2] = on_lvl;
            end else begin
                seg_lvl[2*s +: 2] = sel_lvl;
            end
        end
        assign seg_oe[s] = ~grp_release[G];
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_mux_pkg::*;
#(
    parameter int NUM_SEG   = 20,
    parameter int NUM_COM   = 4,
    parameter int FRAME_CYC = 1000,
    parameter int GRP_SIZE  = 4,
    localparam int NUM_GRP  = (NUM_SEG + GRP_SIZE - 1) / GRP_SIZE,
    localparam int AW       = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 backup,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [NUM_COM-1:0]   wr_nib,
    input  logic [NUM_GRP-1:0]   grp_release,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl,
    output logic [NUM_SEG-1:0]   seg_oe
);

    localparam int SLOT_CYC = FRAME_CYC / NUM_COM;
    localparam int SW       = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

    logic                            run_req;
    logic                            running;
    logic [SW-1:0]                   slot;
    logic                            pol;
    logic                            slot_end;
    logic                            load;
    logic [NUM_SEG-1:0][NUM_COM-1:0] shown;

    assign run_req = enable & ~backup;
    // load at every slot boundary, and keep loading while idle so drive starts fresh
    assign load    = slot_end | ~running;

    lcd_mux_timebase #(
        .SLOT_CYC (SLOT_CYC),
        .NUM_COM  (NUM_COM)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .running  (running),
        .slot     (slot),
        .pol      (pol),
        .slot_end (slot_end)
    );

    lcd_mux_pattern #(
        .NUM_SEG (NUM_SEG),
        .NUM_COM (NUM_COM)
    ) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_nib  (wr_nib),
        .load    (load),
        .shown   (shown)
    );

    lcd_mux_encoder #(
        .NUM_SEG  (NUM_SEG),
        .NUM_COM  (NUM_COM),
        .GRP_SIZE (GRP_SIZE)
    ) u_encoder (
        .running     (running),
        .slot        (slot),
        .pol         (pol),
        .shown       (shown),
        .grp_release (grp_release),
        .com_lvl     (com_lvl),
        .seg_lvl     (seg_lvl),
        .seg_oe      (seg_oe)
    );

    logic [NUM_COM-1:0] com_active;
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com_act
        assign com_active[c] = (com_lvl[2*c +: 2] != LVL_MID);
    end

    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ($countones(com_active) == 1)); // R1

    AST_BACKUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        backup |=> (com_lvl == '0 && seg_lvl == '0)); // R5

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_chk
        AST_SEG_NOT_MID: assert property (@(posedge clk) disable iff (!rst_n)
            (running && !grp_release[s / GRP_SIZE]) |-> (seg_lvl[2*s +: 2] != LVL_MID)); // R3
        AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            grp_release[s / GRP_SIZE] |-> (!seg_oe[s] && seg_lvl[2*s +: 2] == LVL_LOW)); // R8
    end

endmodule

// File: tb/sim_lcd_mux_driver.sv
module sim_lcd_mux_driver;

    localparam int NSEG  = 20;
    localparam int NCOM  = 4;
    localparam int FRAME = 1000;
    localparam int SLOT  = FRAME / NCOM;
    localparam int NGRP  = 5;
    localparam int AWD   = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                enable = 1'b0;
    logic                backup = 1'b0;
    logic                wr_en = 1'b0;
    logic [AWD-1:0]      wr_addr = '0;
    logic [NCOM-1:0]     wr_nib = '0;
    logic [NGRP-1:0]     grp_release = '0;
    logic [2*NCOM-1:0]   com_lvl;
    logic [2*NSEG-1:0]   seg_lvl;
    logic [NSEG-1:0]     seg_oe;

    always #2 clk = ~clk;

    lcd_mux_driver #(
        .NUM_SEG   (NSEG),
        .NUM_COM   (NCOM),
        .FRAME_CYC (FRAME),
        .GRP_SIZE  (4)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .backup      (backup),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_nib      (wr_nib),
        .grp_release (grp_release),
        .com_lvl     (com_lvl),
        .seg_lvl     (seg_lvl),
        .seg_oe      (seg_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // ---------------- behavioural reference ----------------
    int m_run, m_tick, m_slot, m_pol;
    int m_stage[NSEG];
    int m_show[NSEG];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_tick = 0; m_slot = 0; m_pol = 0;
            for (int s = 0; s < NSEG; s++) begin
                m_stage[s] = 0;
                m_show[s]  = 0;
            end
        end else begin
            if (m_run == 0 || m_tick == SLOT - 1)
                for (int s = 0; s < NSEG; s++) m_show[s] = m_stage[s];
            if (wr_en && int'(wr_addr) < NSEG) m_stage[wr_addr] = int'(wr_nib);
            if (!(enable && !backup) || m_run == 0) begin
                m_tick = 0; m_slot = 0; m_pol = 0;
            end else if (m_tick == SLOT - 1) begin
                m_tick = 0;
                if (m_slot == NCOM - 1) begin
                    m_slot = 0;
                    m_pol  = 1 - m_pol;
                end else begin
                    m_slot = m_slot + 1;
                end
            end else begin
                m_tick = m_tick + 1;
            end
            m_run = (enable && !backup) ? 1 : 0;
        end
    end

    // every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2*NCOM-1:0] e_com;
            logic [2*NSEG-1:0] e_seg;
            logic [NSEG-1:0]   e_oe;
            logic [1:0]        sel;
            sel = (m_pol != 0) ? 2'b00 : 2'b10;
            for (int c = 0; c < NCOM; c++)
                e_com[2*c +: 2] = (m_run == 0) ? 2'b00 : ((c == m_slot) ? sel : 2'b01);
            for (int s = 0; s < NSEG; s++) begin
                e_oe[s] = ~grp_release[s / 4];
                if (m_run == 0 || grp_release[s / 4])
                    e_seg[2*s +: 2] = 2'b00;
                else if (((m_show[s] >> m_slot) & 1) != 0)
                    e_seg[2*s +: 2] = 2'b10 - sel;
                else
                    e_seg[2*s +: 2] = sel;
            end
            n_cmp += 3;
            if (com_lvl !== e_com) begin
                n_bad++;
                $display("FAIL %s com_lvl act=%h exp=%h t=%0t",
                         (m_run == 0) ? (backup ? "R5" : "R6") : "R2", com_lvl, e_com, $time);
            end
            if (seg_lvl !== e_seg) begin
                n_bad++;
                $display("FAIL %s seg_lvl act=%h exp=%h t=%0t",
                         (m_run == 0) ? (backup ? "R5" : "R6") : "R3", seg_lvl, e_seg, $time);
            end
            if (seg_oe !== e_oe) begin
                n_bad++;
                $display("FAIL R8 seg_oe act=%h exp=%h t=%0t", seg_oe, e_oe, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int nib);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = AWD'(a); wr_nib = NCOM'(nib);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired");
        summary();
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int cnt;
        logic [1:0] first_lvl;
        step(5);
        rst_n = 1'b1;
        step(20);
        @(negedge clk);
        // R6: idle after reset
        chk(com_lvl == '0 && seg_lvl == '0, "R6 idle low", {com_lvl, seg_lvl}, 64'h0);

        enable = 1'b1;
        step(1);
        @(negedge clk);
        // R6: first driven cycle is slot 0, even polarity
        chk(com_lvl == 8'b01_01_01_10, "R6 start slot0", com_lvl, 8'b01_01_01_10);
        // R9: cleared pattern shows all segments off (same as selected level)
        chk(seg_lvl == {NSEG{2'b10}}, "R9 all off", seg_lvl, {NSEG{2'b10}});

        // R1: common 1 stays selected for SLOT cycles
        while (com_lvl[3:2] == 2'b01) @(negedge clk);
        first_lvl = com_lvl[3:2];
        cnt = 0;
        while (com_lvl[3:2] != 2'b01) begin cnt++; @(negedge clk); end
        chk(cnt == SLOT, "R1 slot length", 64'(cnt), 64'(SLOT));
        chk(first_lvl == 2'b10, "R2 even frame high", 64'(first_lvl), 64'h2);

        // R4: next frame inverts
        while (com_lvl[1:0] == 2'b01) @(negedge clk);
        chk(com_lvl[1:0] == 2'b00, "R4 odd frame low", 64'(com_lvl[1:0]), 64'h0);

        // R7: write early in slot 0, visible only from slot 1
        while (com_lvl[1:0] != 2'b01) @(negedge clk);
        while (com_lvl[1:0] == 2'b01) @(negedge clk);
        wr(0, 4'b1111);
        @(negedge clk);
        chk(seg_lvl[1:0] == com_lvl[1:0], "R7 deferred", 64'(seg_lvl[1:0]), 64'(com_lvl[1:0]));
        while (com_lvl[3:2] == 2'b01) @(negedge clk);
        chk(seg_lvl[1:0] == (2'b10 - com_lvl[3:2]), "R7 applied", 64'(seg_lvl[1:0]),
            64'(2'b10 - com_lvl[3:2]));

        // R7: bulk pattern plus out-of-range addresses (checked by model)
        for (int s = 0; s < 32; s++) wr(s, (s * 7 + 3) % 16);
        step(2 * FRAME);

        // R5: backup forces low, restart afterwards
        backup = 1'b1;
        step(1);
        @(negedge clk);
        chk(com_lvl == '0 && seg_lvl == '0, "R5 backup low", {com_lvl, seg_lvl}, 64'h0);
        step(30);
        backup = 1'b0;
        step(1);
        @(negedge clk);
        chk(com_lvl == 8'b01_01_01_10, "R5 restart slot0", com_lvl, 8'b01_01_01_10);

        // R8: release groups 0 and 2
        @(posedge clk); #1;
        grp_release = 5'b00101;
        #1;
        chk(seg_oe == 20'hFF0F0 && seg_lvl[7:0] == 8'h00, "R8 release", {44'h0, seg_oe}, 64'hFF0F0);

        // random writes, including slot-boundary cycles (model checks R3, R7)
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); #1;
            wr_en   = ($urandom % 3) == 0;
            wr_addr = AWD'($urandom % 32);
            wr_nib  = NCOM'($urandom);
            if (k == 1500) grp_release = 5'b11000;
            if (k == 2300) enable = 1'b0;
            if (k == 2350) enable = 1'b1;
        end
        wr_en = 1'b0;
        grp_release = '0;
        step(FRAME);

        summary();
        $finish;
    end

endmodule